// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block records the value of an external free-running 16-bit count into a capture register when a chosen edge appears on an event line. The event line is taken from one of two sources: a dedicated capture pin or the output bit of an analog comparator. A select input picks the source. The chosen signal passes through a two-flop synchronizer. It can then go through a four-sample majority-free agreement filter, which changes its output only when four successive samples agree. After that comes an edge-detecting state machine. When a capture happens, a sticky flag is raised. Software clears the flag with a dedicated clear strobe.

The capture register doubles as the timer's top value. While the mode input says the register defines the top, no hardware capture occurs. In that mode the register can be written through the byte-wide bus. A 16-bit write places the high byte in a shared temporary byte first; the low-byte write then commits both bytes. A low-byte read latches the high byte into the same temporary byte, so a following high-byte read is coherent.

The edge detector is a three-state machine:
- LOW: the filtered level is 0.
- HIGH: the filtered level is 1.
- TOP: the register serves as the top value.

Transitions:
- LOW→HIGH on a level of 1. This captures when the rising edge is selected.
- HIGH→LOW on a level of 0. This captures when the falling edge is selected.
- LOW/HIGH→TOP when the mode input rises.
- TOP→LOW or TOP→HIGH, following the present level, when the mode input falls. This exit never captures.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register is 0, the flag is 0, and the read data output is 0 whenever no read is requested.
- R2: With the rising edge selected (edge_rise_i=1), a 0→1 change on the selected source present at clock edge k loads the count value present at edge k+2 into the register, and a 1→0 change loads nothing.
- R3: With the falling edge selected (edge_rise_i=0), a 1→0 change captures with the same timing as R2, and a 0→1 change loads nothing.
- R4: src_sel_i=0 selects the capture pin and src_sel_i=1 selects the comparator bit; changes on the unselected source cause no capture.
- R5: Changing src_sel_i while the two sources differ behaves as an edge on the event line and captures with R2 timing when that edge matches the selected polarity.
- R6: With flt_en_i=1 the capture happens at edge k+6, exactly four clocks later than without the filter.
- R7: With the filter enabled, a pulse shorter than four clock samples produces no capture.
- R8: The flag sets in the cycle the register loads and stays set until flag_clr_i; a capture and a clear in the same cycle leave the flag set.
- R9: While top_mode_i=1 no capture occurs, and leaving that mode does not by itself cause a capture.
- R10: A write to the high-byte address (bus_addr_i=1) stores the byte in the temporary byte. A following low-byte write (bus_addr_i=0) commits {temporary, low} to the register only while top_mode_i=1; otherwise the low write is ignored.
- R11: A low-byte read returns the register's low byte and copies its high byte into the temporary byte; a high-byte read returns the temporary byte.
- R12: A later capture overwrites the register whether or not the earlier value was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the filter |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Free-running timer count |
| top_mode_i | input | 1 | 1 = capture register defines the counter top |
| cap_pin_i | input | 1 | External capture pin |
| cmp_out_i | input | 1 | Analog comparator output bit |
| src_sel_i | input | 1 | 0 = pin, 1 = comparator |
| flt_en_i | input | 1 | Enable four-sample filter |
| edge_rise_i | input | 1 | 1 = rising edge, 0 = falling edge |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe |
| bus_addr_i | input | 1 | 0 = low byte, 1 = high byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when no read |
| cap_flag_o | output | 1 | Sticky capture flag |
| flag_clr_i | input | 1 | Flag clear strobe |

## Verification
A vector table changes one source at a time across combinations of source, polarity and filter setting. Matching edges, opposite edges and edges on the unselected source are each shown to capture or not. In each capturing case the captured count is compared against the k+2 or k+6 expectation, which separates the filtered latency from the unfiltered one. Directed sequences then cover the source-switch edge, a three-sample glitch under the filter, and back-to-back captures. They also cover clear-versus-set collision, top-mode writes and ignored writes, and the temporary-byte read ordering.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_TOP  = 2'd2
    } lvl_state_t;

    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/icap_sync_filter.sv
module icap_sync_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FLT_DEPTH   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic flt_en,
    output logic level_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FLT_DEPTH-1:0]   hist_q;
    logic                   flt_q;
    logic                   flt_next;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
            flt_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FLT_DEPTH-2:0], sync_out};
            flt_q  <= flt_next;
        end
    end

    // output moves only when every stored sample agrees
    always_comb begin
        if (&hist_q)       flt_next = 1'b1;
        else if (~|hist_q) flt_next = 1'b0;
        else               flt_next = flt_q;
    end

    assign level_o = flt_en ? flt_next : sync_out;
endmodule

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic top_mode,
    input  logic level,
    input  logic rise_sel,
    output logic cap_ld_o
);
    lvl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TOP:  if (!top_mode) state_d = level ? ST_HIGH : ST_LOW;
            ST_LOW:  if (top_mode) state_d = ST_TOP;
                     else if (level) state_d = ST_HIGH;
            ST_HIGH: if (top_mode) state_d = ST_TOP;
                     else if (!level) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_comb begin
        cap_ld_o = 1'b0;
        unique case (state_q)
            ST_LOW:  cap_ld_o = !top_mode && level && rise_sel;
            ST_HIGH: cap_ld_o = !top_mode && !level && !rise_sel;
            default: cap_ld_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_regs.sv
module icap_regs
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               cap_ld,
    input  logic               top_mode,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               addr,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               flag_clr,
    output logic [CNT_W-1:0]   cap_q,
    output logic [CNT_W/2-1:0] tmp_q,
    output logic               flag_o,
    output logic [CNT_W/2-1:0] rdata_o
);
    localparam int unsigned BYTE_W = CNT_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            tmp_q  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (cap_ld)
                cap_q <= cnt_i;
            else if (wr_en && addr == ADDR_LO && top_mode)
                cap_q <= {tmp_q, wdata};

            if (wr_en && addr == ADDR_HI)
                tmp_q <= wdata;
            else if (rd_en && addr == ADDR_LO)
                tmp_q <= cap_q[CNT_W-1:BYTE_W];

            if (cap_ld)        flag_o <= 1'b1;
            else if (flag_clr) flag_o <= 1'b0;
        end
    end

    always_comb begin
        if (!rd_en)               rdata_o = '0;
        else if (addr == ADDR_HI) rdata_o = tmp_q;
        else                      rdata_o = cap_q[BYTE_W-1:0];
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FLT_DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               top_mode_i,
    input  logic               cap_pin_i,
    input  logic               cmp_out_i,
    input  logic               src_sel_i,
    input  logic               flt_en_i,
    input  logic               edge_rise_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic               bus_addr_i,
    input  logic [CNT_W/2-1:0] bus_wdata_i,
    output logic [CNT_W/2-1:0] bus_rdata_o,
    output logic               cap_flag_o,
    input  logic               flag_clr_i
);
    localparam int unsigned BYTE_W = CNT_W / 2;

    logic              evt_raw;
    logic              evt_level;
    logic              cap_ld;
    logic [CNT_W-1:0]  cap_q;
    logic [BYTE_W-1:0] tmp_q;

    // source mux sits ahead of the synchronizer, so a select change looks like an edge
    assign evt_raw = src_sel_i ? cmp_out_i : cap_pin_i;

    icap_sync_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FLT_DEPTH   (FLT_DEPTH)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (evt_raw),
        .flt_en  (flt_en_i),
        .level_o (evt_level)
    );

    icap_edge_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_mode (top_mode_i),
        .level    (evt_level),
        .rise_sel (edge_rise_i),
        .cap_ld_o (cap_ld)
    );

    icap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt_i),
        .cap_ld   (cap_ld),
        .top_mode (top_mode_i),
        .wr_en    (bus_wr_i),
        .rd_en    (bus_rd_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .flag_clr (flag_clr_i),
        .cap_q    (cap_q),
        .tmp_q    (tmp_q),
        .flag_o   (cap_flag_o),
        .rdata_o  (bus_rdata_o)
    );
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cnt_i,
    input logic               top_mode_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic               bus_addr_i,
    input logic               flag_clr_i,
    input logic               cap_flag_o,
    input logic               cap_ld,
    input logic [CNT_W-1:0]   cap_q,
    input logic [CNT_W/2-1:0] tmp_q
);
    p_cap_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ld |=> cap_q == $past(cnt_i));

    p_flag_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ld |=> cap_flag_o);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

    p_top_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mode_i && !(bus_wr_i && bus_addr_i == 1'b0)) |=> $stable(cap_q));

    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_mode_i && !cap_ld) |=> $stable(cap_q));

    p_read_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && bus_addr_i == 1'b0) |=> tmp_q == $past(cap_q[CNT_W-1:CNT_W/2]));
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .top_mode_i (top_mode_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .flag_clr_i (flag_clr_i),
    .cap_flag_o (cap_flag_o),
    .cap_ld     (cap_ld),
    .cap_q      (cap_q),
    .tmp_q      (tmp_q)
);

// File: tb/icap_unit_test.sv
module icap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'd0;
    logic        top_mode = 1'b0, pin = 1'b0, cmp = 1'b0, sel = 1'b0;
    logic        flt = 1'b0, rise = 1'b1, wr = 1'b0, rd = 1'b0, addr = 1'b0, clr = 1'b0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        flag;
    int          tests = 0;
    int          fails = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    icap_unit uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .top_mode_i(top_mode),
        .cap_pin_i(pin), .cmp_out_i(cmp), .src_sel_i(sel), .flt_en_i(flt),
        .edge_rise_i(rise), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_flag_o(flag), .flag_clr_i(clr)
    );

    // {sel, flt, rise, pin, cmp, expect_capture, latency[3:0]}
    localparam logic [9:0] VEC [10] = '{
        10'b0_0_1_1_0_1_0010, // R2 rising captures
        10'b0_0_1_0_0_0_0110, // R2 falling ignored
        10'b0_0_0_1_0_0_0110, // R3 rising ignored
        10'b0_0_0_0_0_1_0010, // R3 falling captures
        10'b0_0_1_0_1_0_0110, // R4 comparator ignored while pin selected
        10'b1_0_0_0_0_1_0010, // R4 comparator selected
        10'b1_1_1_0_1_1_0110, // R6 filtered rising
        10'b1_1_0_0_0_1_0110, // R6 filtered falling
        10'b0_1_1_1_0_1_0110, // R6 filtered pin
        10'b0_0_1_0_0_0_0110  // R2 falling ignored again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        @(negedge clk); rd = 1'b1; addr = 1'b0;
        #1 v[7:0] = rdata;
        @(negedge clk); addr = 1'b1;
        #1 v[15:8] = rdata;
        rd = 1'b0;
    endtask

    task automatic wr8(input logic a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] n;
        logic [15:0] n2;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check("R1 flag", flag, 0);
        check("R1 rdata idle", rdata, 0);
        rd16(v);
        check("R1 capture reg", v, 0);

        // table: R2 R3 R4 R6
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sel = VEC[i][9]; flt = VEC[i][8]; rise = VEC[i][7];
            tick(10);
            clear_flag();
            @(negedge clk);
            pin = VEC[i][6]; cmp = VEC[i][5];
            n = cnt;
            tick(int'(VEC[i][3:0]));
            check($sformatf("R2/R3/R4/R6 vec%0d early flag", i), flag, 0);
            tick(1);
            check($sformatf("R2/R3/R4/R6 vec%0d flag", i), flag, VEC[i][4]);
            if (VEC[i][4]) begin
                rd16(v);
                check($sformatf("R2/R3/R4/R6 vec%0d value", i), v, n + 16'(VEC[i][3:0]));
            end
        end

        // R5 source switch fires a capture
        @(negedge clk); sel = 1'b0; flt = 1'b0; rise = 1'b1; pin = 1'b0; cmp = 1'b1;
        tick(10);
        clear_flag();
        @(negedge clk); sel = 1'b1; n = cnt;
        tick(2);
        check("R5 early flag", flag, 0);
        tick(1);
        check("R5 flag", flag, 1);
        rd16(v);
        check("R5 value", v, n + 16'd2);
        @(negedge clk); sel = 1'b0; cmp = 1'b0;

        // R7 short pulse rejected by filter
        @(negedge clk); flt = 1'b1;
        tick(10);
        clear_flag();
        @(negedge clk); pin = 1'b1;
        tick(3);
        pin = 1'b0;
        tick(12);
        check("R7 glitch flag", flag, 0);

        // R12 overwrite
        @(negedge clk); flt = 1'b0;
        tick(5);
        @(negedge clk); pin = 1'b1;
        tick(10);
        @(negedge clk); pin = 1'b0;
        tick(10);
        @(negedge clk); pin = 1'b1; n2 = cnt;
        tick(3);
        rd16(v);
        check("R12 overwrite value", v, n2 + 16'd2);

        // R8 sticky flag and collision
        tick(5);
        check("R8 sticky", flag, 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk);
        check("R8 cleared", flag, 0);
        pin = 1'b0;
        tick(8);
        @(negedge clk); pin = 1'b1;
        tick(3);
        check("R8 set wins over clear", flag, 1);
        tick(1);
        check("R8 clear after collision", flag, 0);
        clr = 1'b0;

        // R9 / R10 top mode
        @(negedge clk); pin = 1'b0; top_mode = 1'b1;
        tick(3);
        clear_flag();
        @(negedge clk); pin = 1'b1;
        tick(8);
        @(negedge clk); pin = 1'b0;
        tick(8);
        @(negedge clk); pin = 1'b1;
        tick(8);
        check("R9 no capture in top mode", flag, 0);
        wr8(1'b1, 8'hBE);
        wr8(1'b0, 8'hEF);
        rd16(v);
        check("R10 top write commit", v, 16'hBEEF);
        @(negedge clk); top_mode = 1'b0;
        tick(10);
        check("R9 exit no capture", flag, 0);
        wr8(1'b1, 8'h12);
        wr8(1'b0, 8'h34);
        rd16(v);
        check("R10 write ignored", v, 16'hBEEF);

        // R11 temporary byte ordering
        wr8(1'b1, 8'h5A);
        @(negedge clk); rd = 1'b1; addr = 1'b1;
        #1 check("R11 high read returns temp", rdata, 8'h5A);
        rd = 1'b0;
        @(negedge clk); rd = 1'b1; addr = 1'b0;
        #1 check("R11 low read", rdata, 8'hEF);
        @(negedge clk); addr = 1'b1;
        #1 check("R11 latched high", rdata, 8'hBE);
        rd = 1'b0;

        tick(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule